// File: doc/BRIEF.md
# Paged Memory Management Unit

The block turns a 16-bit CPU address into a 26-bit physical address. The upper four address bits pick one of sixteen 4 KB frames. Each frame holds a 14-bit physical page number, and that number is placed ahead of the 12-bit offset, which passes through unchanged. Translation is combinational, so the physical address follows the CPU address within the same cycle. The 26-bit space includes the ROM, the SRAM, and both a cached and an uncached view of the same SDRAM, so any frame can point at any of them.

Software programs the table through a block of eight I/O ports, addressed here by a 3-bit offset:

- Offset 0 selects the frame to be accessed.
- Offset 4 holds the high part of the selected frame's page number.
- Offset 5 holds the low byte of the selected frame's page number.

All three can be read back. The table comes out of reset with a fixed map:

- ROM is in frame 0.
- SRAM is in frame 15.
- The frames in between map to the matching SDRAM pages.

Boot code can later move the ROM to frame 15 and put SDRAM page 0 in frame 0.

Top module: `paged_mmu`

## Requirements
- R1: The low 12 bits of `phys_addr_o` always equal the low 12 bits of `cpu_addr_i`.
- R2: `phys_addr_o[25:12]` equals the 14-bit page number currently stored for frame `cpu_addr_i[15:12]`, including after the table has been rewritten to move the ROM into frame 15 and SDRAM page 0 into frame 0.
- R3: After reset the page numbers are:
  - frame 0: 0x2000 (physical 0x2000000);
  - frame 15: 0x2001 (physical 0x2001000);
  - every other frame N: N.
- R4: A write to offset 0 stores `io_wdata_i[3:0]` as the selected frame and ignores bits 7:4. A read of offset 0 returns the selected frame in bits 3:0, with bits 7:4 zero.
- R5: A write to offset 4 stores `io_wdata_i[5:0]` into page bits 13:8 of the selected frame and ignores bits 7:6. A read of offset 4 returns those six bits, with bits 7:6 zero.
- R6: A write to offset 5 stores `io_wdata_i` into page bits 7:0 of the selected frame. A read of offset 5 returns them.
- R7: Offsets 1, 2, 3, 6 and 7 read as zero, and writes to them change neither the table nor the selected frame.
- R8: A write happens only on a rising clock edge with both `io_sel_i` and `io_we_i` high. Its effect on `phys_addr_o` and `io_rdata_o` appears after that edge and not before.
- R9: After reset the selected frame is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_addr_i | input | 16 | CPU logical address |
| phys_addr_o | output | 26 | Translated physical address |
| io_sel_i | input | 1 | I/O access addresses this block |
| io_we_i | input | 1 | I/O write strobe |
| io_offs_i | input | 3 | Port offset within the block |
| io_wdata_i | input | 8 | I/O write data |
| io_rdata_o | output | 8 | I/O read data for the addressed offset |

## Verification
The assertions assume that `cpu_addr_i` and the I/O inputs are stable and known around each rising edge. They also assume that a CPU address held across an edge with no write at that edge should give the same translation. The bench changes inputs only on falling edges and holds every write for exactly one rising edge. It then releases the strobes, so each mapping change is tied to a single known edge. The random writes cover all eight offsets, both states of `io_sel_i`, and full 8-bit data. This exercises the ignored data bits and the unused offsets without breaking those assumptions.

// File: rtl/mmu_pkg.sv
package mmu_pkg;

  typedef enum logic [2:0] {
    PORT_FRAME  = 3'd0,
    PORT_PPN_HI = 3'd4,
    PORT_PPN_LO = 3'd5
  } mmu_port_e;

  // reset page for a frame: ROM at the bottom, SRAM at the top, identity between
  function automatic logic [31:0] reset_ppn(int unsigned idx, int unsigned last,
                                            int unsigned rom, int unsigned sram);
    if (idx == 0)    return 32'(rom);
    if (idx == last) return 32'(sram);
    return 32'(idx);
  endfunction

endpackage

// File: rtl/mmu_io_decode.sv
module mmu_io_decode #(
  parameter int unsigned FRAME_W = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               io_sel_i,
  input  logic               io_we_i,
  input  logic [2:0]         io_offs_i,
  input  logic [FRAME_W-1:0] frame_d_i,
  output logic               hi_we_o,
  output logic               lo_we_o,
  output logic [FRAME_W-1:0] cur_frame_o
);
  import mmu_pkg::*;

  logic wr_en;
  logic frame_we;
  logic [FRAME_W-1:0] cur_frame_q;

  assign wr_en    = io_sel_i & io_we_i;
  assign frame_we = wr_en && (io_offs_i == PORT_FRAME);
  assign hi_we_o  = wr_en && (io_offs_i == PORT_PPN_HI);
  assign lo_we_o  = wr_en && (io_offs_i == PORT_PPN_LO);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cur_frame_q <= '0;
    else if (frame_we) cur_frame_q <= frame_d_i;
  end

  assign cur_frame_o = cur_frame_q;

endmodule

// File: rtl/mmu_frame_table.sv
module mmu_frame_table #(
  parameter int unsigned FRAME_W  = 4,
  parameter int unsigned PPN_W    = 14,
  parameter int unsigned ROM_PPN  = 32'h2000,
  parameter int unsigned SRAM_PPN = 32'h2001,
  localparam int unsigned NFRAMES = 1 << FRAME_W,
  localparam int unsigned HI_W    = PPN_W - 8
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            hi_we_i,
  input  logic                            lo_we_i,
  input  logic [FRAME_W-1:0]              cur_frame_i,
  input  logic [HI_W-1:0]                 hi_d_i,
  input  logic [7:0]                      lo_d_i,
  output logic [NFRAMES-1:0][PPN_W-1:0]   ppn_tab_o,
  output logic [PPN_W-1:0]                cur_ppn_o
);

  for (genvar g = 0; g < NFRAMES; g++) begin : g_frame
    localparam logic [PPN_W-1:0] RST_PPN =
      PPN_W'(mmu_pkg::reset_ppn(g, NFRAMES - 1, ROM_PPN, SRAM_PPN));

    logic hit;
    logic [PPN_W-1:0] ppn_q;

    assign hit = (cur_frame_i == FRAME_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ppn_q <= RST_PPN;
      end else begin
        if (hi_we_i && hit) ppn_q[PPN_W-1:8] <= hi_d_i;
        if (lo_we_i && hit) ppn_q[7:0]       <= lo_d_i;
      end
    end

    assign ppn_tab_o[g] = ppn_q;
  end

  assign cur_ppn_o = ppn_tab_o[cur_frame_i];

endmodule

// File: rtl/mmu_xlate.sv
module mmu_xlate #(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned PAGE_BITS = 12,
  parameter int unsigned PPN_W     = 14,
  localparam int unsigned FRAME_W  = ADDR_W - PAGE_BITS,
  localparam int unsigned NFRAMES  = 1 << FRAME_W
) (
  input  logic [ADDR_W-1:0]              cpu_addr_i,
  input  logic [NFRAMES-1:0][PPN_W-1:0]  ppn_tab_i,
  output logic [PPN_W+PAGE_BITS-1:0]     phys_addr_o
);

  logic [FRAME_W-1:0] frame;

  assign frame       = cpu_addr_i[ADDR_W-1:PAGE_BITS];
  assign phys_addr_o = {ppn_tab_i[frame], cpu_addr_i[PAGE_BITS-1:0]};

endmodule

// File: rtl/paged_mmu.sv
module paged_mmu #(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned PAGE_BITS = 12,
  parameter int unsigned PHYS_W    = 26,
  parameter int unsigned ROM_PPN   = 32'h2000,
  parameter int unsigned SRAM_PPN  = 32'h2001
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  output logic [PHYS_W-1:0] phys_addr_o,
  input  logic              io_sel_i,
  input  logic              io_we_i,
  input  logic [2:0]        io_offs_i,
  input  logic [7:0]        io_wdata_i,
  output logic [7:0]        io_rdata_o
);
  import mmu_pkg::*;

  localparam int unsigned FRAME_W = ADDR_W - PAGE_BITS;
  localparam int unsigned NFRAMES = 1 << FRAME_W;
  localparam int unsigned PPN_W   = PHYS_W - PAGE_BITS;
  localparam int unsigned HI_W    = PPN_W - 8;

  logic                           hi_we, lo_we;
  logic [FRAME_W-1:0]             cur_frame;
  logic [NFRAMES-1:0][PPN_W-1:0]  ppn_tab;
  logic [PPN_W-1:0]               cur_ppn;

  mmu_io_decode #(.FRAME_W(FRAME_W)) u_dec (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .io_sel_i    (io_sel_i),
    .io_we_i     (io_we_i),
    .io_offs_i   (io_offs_i),
    .frame_d_i   (io_wdata_i[FRAME_W-1:0]),
    .hi_we_o     (hi_we),
    .lo_we_o     (lo_we),
    .cur_frame_o (cur_frame)
  );

  mmu_frame_table #(
    .FRAME_W  (FRAME_W),
    .PPN_W    (PPN_W),
    .ROM_PPN  (ROM_PPN),
    .SRAM_PPN (SRAM_PPN)
  ) u_tab (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .hi_we_i     (hi_we),
    .lo_we_i     (lo_we),
    .cur_frame_i (cur_frame),
    .hi_d_i      (io_wdata_i[HI_W-1:0]),
    .lo_d_i      (io_wdata_i),
    .ppn_tab_o   (ppn_tab),
    .cur_ppn_o   (cur_ppn)
  );

  mmu_xlate #(
    .ADDR_W    (ADDR_W),
    .PAGE_BITS (PAGE_BITS),
    .PPN_W     (PPN_W)
  ) u_xl (
    .cpu_addr_i  (cpu_addr_i),
    .ppn_tab_i   (ppn_tab),
    .phys_addr_o (phys_addr_o)
  );

  always_comb begin
    case (io_offs_i)
      PORT_FRAME:  io_rdata_o = 8'(cur_frame);
      PORT_PPN_HI: io_rdata_o = 8'(cur_ppn[PPN_W-1:8]);
      PORT_PPN_LO: io_rdata_o = cur_ppn[7:0];
      default:     io_rdata_o = '0;
    endcase
  end

endmodule

// File: rtl/mmu_checks.sv
module mmu_checks #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned PHYS_W = 26
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] cpu_addr_i,
  input logic [PHYS_W-1:0] phys_addr_o,
  input logic              io_sel_i,
  input logic              io_we_i,
  input logic [2:0]        io_offs_i,
  input logic [7:0]        io_wdata_i,
  input logic [7:0]        io_rdata_o
);

  a_r4_frame_read_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_offs_i == 3'd0) |-> (io_rdata_o[7:4] == 4'h0));

  a_r4_frame_readback: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_sel_i && io_we_i && io_offs_i == 3'd0) |=>
      ((io_offs_i == 3'd0) -> (io_rdata_o[3:0] == $past(io_wdata_i[3:0]))));

  a_r5_hi_read_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_offs_i == 3'd4) |-> (io_rdata_o[7:6] == 2'b00));

  a_r6_lo_readback: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_sel_i && io_we_i && io_offs_i == 3'd5) |=>
      ((io_offs_i == 3'd5) -> (io_rdata_o == $past(io_wdata_i))));

  a_r7_unused_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(io_offs_i inside {3'd0, 3'd4, 3'd5}) |-> (io_rdata_o == 8'h00));

  a_r8_no_write_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(io_sel_i && io_we_i) |=> ($stable(cpu_addr_i) -> $stable(phys_addr_o)));

endmodule

bind paged_mmu mmu_checks #(.ADDR_W(ADDR_W), .PHYS_W(PHYS_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cpu_addr_i  (cpu_addr_i),
  .phys_addr_o (phys_addr_o),
  .io_sel_i    (io_sel_i),
  .io_we_i     (io_we_i),
  .io_offs_i   (io_offs_i),
  .io_wdata_i  (io_wdata_i),
  .io_rdata_o  (io_rdata_o)
);

// File: tb/sim_paged_mmu.sv
module sim_paged_mmu;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [25:0] phys_addr;
  logic        io_sel = 1'b0, io_we = 1'b0;
  logic [2:0]  io_offs = '0;
  logic [7:0]  io_wdata = '0;
  logic [7:0]  io_rdata;

  int n_chk = 0, n_fail = 0;
  logic [13:0] m_ppn [16];
  logic [3:0]  m_cur;

  always #(CLK_PERIOD/2) clk = ~clk;

  paged_mmu u0 (
    .clk_i(clk), .rst_ni(rst_n), .cpu_addr_i(cpu_addr), .phys_addr_o(phys_addr),
    .io_sel_i(io_sel), .io_we_i(io_we), .io_offs_i(io_offs),
    .io_wdata_i(io_wdata), .io_rdata_o(io_rdata)
  );

  function automatic logic [25:0] exp_phys(logic [15:0] a);
    return {m_ppn[a[15:12]], a[11:0]};
  endfunction

  function automatic logic [7:0] exp_rd(logic [2:0] o);
    case (o)
      3'd0: return {4'h0, m_cur};
      3'd4: return {2'b00, m_ppn[m_cur][13:8]};
      3'd5: return m_ppn[m_cur][7:0];
      default: return 8'h00;
    endcase
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_xlate(string req, logic [15:0] a);
    cpu_addr = a;
    #1;
    check(req, 32'(phys_addr), 32'(exp_phys(a)));
  endtask

  task automatic chk_read(string req, logic [2:0] o);
    io_offs = o;
    #1;
    check(req, 32'(io_rdata), 32'(exp_rd(o)));
  endtask

  task automatic chk_all(string req);
    for (int f = 0; f < 16; f++) chk_xlate(req, {4'(f), 12'(f * 37 + 5)});
  endtask

  // drive at a falling edge, hold for one rising edge, release
  task automatic do_write(logic sel, logic [2:0] o, logic [7:0] d);
    @(negedge clk);
    io_sel = sel; io_we = 1'b1; io_offs = o; io_wdata = d;
    @(negedge clk);
    io_sel = 1'b0; io_we = 1'b0;
    if (sel) begin
      case (o)
        3'd0: m_cur = d[3:0];
        3'd4: m_ppn[m_cur][13:8] = d[5:0];
        3'd5: m_ppn[m_cur][7:0] = d;
        default: ;
      endcase
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4242));
    for (int f = 0; f < 16; f++) m_ppn[f] = 14'(f);
    m_ppn[0] = 14'h2000; m_ppn[15] = 14'h2001; m_cur = 4'd0;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R3 reset map, R1 offset passthrough, R9 reset selection
    chk_all("R3");
    chk_xlate("R3", 16'h0000);
    check("R3", 32'(phys_addr), 32'h2000000);
    chk_xlate("R3", 16'hF000);
    check("R3", 32'(phys_addr), 32'h2001000);
    chk_xlate("R1", 16'h7ABC);
    check("R1", 32'(phys_addr[11:0]), 32'hABC);
    chk_read("R9", 3'd0);

    // R4 frame select uses low nibble only
    do_write(1'b1, 3'd0, 8'hF1);
    chk_read("R4", 3'd0);
    check("R4", 32'(io_rdata), 32'h01);

    // R5/R6: 0x01, 0x00 -> page 0x0100
    do_write(1'b1, 3'd4, 8'h01);
    do_write(1'b1, 3'd5, 8'h00);
    chk_xlate("R6", 16'h1234);
    check("R6", 32'(phys_addr), 32'h0100234);
    chk_read("R5", 3'd4);
    chk_read("R6", 3'd5);

    // R5 high bits ignored on write, zero on read
    do_write(1'b1, 3'd4, 8'hFF);
    chk_read("R5", 3'd4);
    check("R5", 32'(io_rdata), 32'h3F);

    // R8: effect only after the edge
    @(negedge clk);
    cpu_addr = 16'h1000;
    io_sel = 1'b1; io_we = 1'b1; io_offs = 3'd5; io_wdata = 8'h77;
    #1;
    check("R8", 32'(phys_addr), 32'(exp_phys(16'h1000)));
    @(negedge clk);
    io_sel = 1'b0; io_we = 1'b0;
    m_ppn[1][7:0] = 8'h77;
    chk_xlate("R8", 16'h1000);
    // R8: write strobe without select is ignored
    do_write(1'b0, 3'd5, 8'h99);
    chk_xlate("R8", 16'h1FFF);

    // R2: ROM relocation sequence
    do_write(1'b1, 3'd0, 8'h0F);
    do_write(1'b1, 3'd4, 8'h20);
    do_write(1'b1, 3'd5, 8'h00);
    do_write(1'b1, 3'd0, 8'h00);
    do_write(1'b1, 3'd4, 8'h00);
    do_write(1'b1, 3'd5, 8'h00);
    chk_xlate("R2", 16'hF010);
    check("R2", 32'(phys_addr), 32'h2000010);
    chk_xlate("R2", 16'h0010);
    check("R2", 32'(phys_addr), 32'h0000010);

    // R7: unused offsets
    for (int o = 0; o < 8; o++) begin
      if (o == 0 || o == 4 || o == 5) continue;
      do_write(1'b1, 3'(o), 8'hA5);
      chk_read("R7", 3'(o));
      chk_read("R7", 3'd0);
    end
    chk_all("R7");

    // random mix
    for (int i = 0; i < 400; i++) begin
      do_write(($urandom % 4) != 0, 3'($urandom), 8'($urandom));
      chk_xlate("R2", 16'($urandom));
      chk_read("R4", 3'($urandom));
    end
    chk_all("R2");

    finish_run();
  end

endmodule